// File: doc/BRIEF.md
# Infrared SIR Transmit Pulse Shaper

This block turns the idle-high NRZ transmit line of a UART into the return-to-zero-inverted pulse train used by serial infrared links. The block watches the line on the 3.6864 MHz reference clock. Each bit period in which the line is low produces exactly one short, active-high pulse on the infrared data output. Bit periods in which the line is high produce nothing. Character framing passes through unchanged, so the start bit and every zero data bit each become one pulse.

Bit timing comes from a rate generator that supplies one sub-bit tick per sixteenth of a bit period. A falling edge on the line marks the start of a low bit and restarts the block's bit timing. After that, every sixteenth tick is a bit boundary, where the line is examined again, so a run of zeros produces one pulse per bit. The pulse width is selected by a single input. The fixed setting gives six reference clocks, which is 1.627 µs. The proportional setting gives three sub-bit ticks, which is 3/16 of the bit period. While the programming-mode input is high, the infrared output and the activity indicator are held inactive. The line and the tick are re-timed through the same short delay, so they stay aligned with each other.

Top module: `irsir_tx_shaper`

## Requirements
- R1: While reset is high and on the first clock after it, ir_pulse is 0 and tx_act_n is 1.
- R2: Each bit period in which nrz_in is low, including the start bit, yields exactly one ir_pulse pulse. High bit periods and an idle-high line yield none.
- R3: With fixed_width = 1 when a pulse starts, the pulse lasts exactly FIXED_CLKS (6) clocks.
- R4: With fixed_width = 0 when a pulse starts, the pulse lasts until the third sub_tick after its start. For a bit that begins on a tick, that is three tick intervals (3/16 of a bit).
- R5: In a run of zero bits, bit boundaries fall every SUB_PER_BIT (16) ticks. Each zero bit after the first gives a pulse whose rise is exactly 16 tick intervals after the previous rise.
- R6: ir_pulse rises SYNC_STAGES+1 (3) clocks after nrz_in falls. Each falling edge restarts bit timing, and the next boundary is the sixteenth tick counted after the edge is seen.
- R7: One clock after prog_mode goes high, ir_pulse is 0 and tx_act_n is 1. A pulse in progress is cut off. If nrz_in is already low when prog_mode drops, no pulse starts until a new falling edge arrives.
- R8: tx_act_n goes low with the start of a low bit. It stays low until a bit boundary finds the line high.
- R9: The width setting is captured when a pulse starts. Changing fixed_width during a pulse does not alter that pulse's length.
- R10: With a tick every 2 clocks (the fastest rate), both width settings give 6-clock pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.6864 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode | input | 1 | High while the link is being reprogrammed; silences both outputs |
| nrz_in | input | 1 | UART transmit line, idle high |
| sub_tick | input | 1 | One-clock strobe, 16 per bit period, from the rate generator |
| fixed_width | input | 1 | 1 = 6-clock pulse, 0 = 3/16-of-bit pulse |
| ir_pulse | output | 1 | Infrared data pulse, active high |
| tx_act_n | output | 1 | Transmit activity indicator, active low |

## Verification
The bench sends whole characters at three tick spacings and checks the exact clock on which each pulse rises and how long it lasts. A design that tested the line at the boundary before its synchronizer had caught up would see the previous bit. It would then merge or drop pulses in zero runs, and the mid-bit indicator samples would be wrong. A separate test starts a zero run off the tick grid to show that the edge restarts the bit timing. A design with a free-running bit counter would place the second pulse at the wrong clock. Further tests flip the width select in mid-pulse, cut a pulse with programming mode, and leave programming mode with the line held low. A design that did not latch the width, did not gate its outputs, or saw a false edge on leaving programming mode would show a wrong width or a stray pulse.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  // Pulse width selection captured at the start of every pulse
  typedef enum logic {
    W_SUBBIT = 1'b0,
    W_FIXED  = 1'b1
  } width_mode_e;

endpackage

// File: rtl/irsir_sync.sv
// Delay line / synchronizer; all stages reset to RESET_VAL.
module irsir_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr_q <= RESET_VAL;
        else     sr_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr_q <= {STAGES{RESET_VAL}};
        else     sr_q <= {sr_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/irsir_bit_tracker.sv
// Finds the start of every low bit: on a falling edge, then at each
// boundary SUB_PER_BIT ticks later while the line stays low.
module irsir_bit_tracker #(
  parameter int SUB_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic line_s,
  input  logic tick_s,
  output logic bit_start,
  output logic active_next
);
  localparam int PH_W = (SUB_PER_BIT > 1) ? $clog2(SUB_PER_BIT) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SUB_PER_BIT - 1);

  logic            line_d_q, line_d_d;
  logic            active_q, active_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            fall;

  always_comb begin
    fall      = line_d_q & ~line_s;
    line_d_d  = line_s;
    active_d  = active_q;
    phase_d   = phase_q;
    bit_start = 1'b0;
    if (hold) begin
      active_d = 1'b0;
      phase_d  = '0;
    end else if (fall) begin
      active_d  = 1'b1;
      phase_d   = '0;
      bit_start = 1'b1;
    end else if (active_q && tick_s) begin
      if (phase_q == LAST_PH) begin
        phase_d   = '0;
        active_d  = ~line_s;
        bit_start = ~line_s;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  assign active_next = active_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_d_q <= 1'b1;
      active_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      line_d_q <= line_d_d;
      active_q <= active_d;
      phase_q  <= phase_d;
    end
  end
endmodule

// File: rtl/irsir_pulse_gen.sv
// Width counter: counts clocks in fixed mode, sub-bit ticks otherwise.
module irsir_pulse_gen
  import irsir_pkg::*;
#(
  parameter int FIXED_CLKS = 6,
  parameter int SUB_PULSE  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic bit_start,
  input  logic tick_s,
  input  logic mode_fixed,
  output logic busy_next
);
  localparam int MAXW  = (FIXED_CLKS > SUB_PULSE) ? FIXED_CLKS : SUB_PULSE;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] LOAD_FIX = CNT_W'(FIXED_CLKS);
  localparam logic [CNT_W-1:0] LOAD_SUB = CNT_W'(SUB_PULSE);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  width_mode_e      mode_q, mode_d;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (hold) begin
      cnt_d = '0;
    end else if (bit_start) begin
      mode_d = mode_fixed ? W_FIXED : W_SUBBIT;
      cnt_d  = mode_fixed ? LOAD_FIX : LOAD_SUB;
    end else if (cnt_q != '0 && (mode_q == W_FIXED || tick_s)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign busy_next = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= W_FIXED;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/irsir_tx_shaper.sv
module irsir_tx_shaper #(
  parameter int SYNC_STAGES = 2,
  parameter int SUB_PER_BIT = 16,
  parameter int SUB_PULSE   = 3,
  parameter int FIXED_CLKS  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_mode,
  input  logic nrz_in,
  input  logic sub_tick,
  input  logic fixed_width,
  output logic ir_pulse,
  output logic tx_act_n
);
  logic line_s, tick_s;
  logic bit_start, active_next, busy_next;
  logic ir_q, act_n_q;

  // Line and tick travel through equal delays so they stay aligned
  irsir_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst(rst), .d(nrz_in), .q(line_s)
  );
  irsir_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_tick_dly (
    .clk(clk), .rst(rst), .d(sub_tick), .q(tick_s)
  );

  irsir_bit_tracker #(.SUB_PER_BIT(SUB_PER_BIT)) u_tracker (
    .clk(clk), .rst(rst), .hold(prog_mode),
    .line_s(line_s), .tick_s(tick_s),
    .bit_start(bit_start), .active_next(active_next)
  );

  irsir_pulse_gen #(.FIXED_CLKS(FIXED_CLKS), .SUB_PULSE(SUB_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .hold(prog_mode),
    .bit_start(bit_start), .tick_s(tick_s),
    .mode_fixed(fixed_width), .busy_next(busy_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q    <= 1'b0;
      act_n_q <= 1'b1;
    end else begin
      ir_q    <= ~prog_mode & busy_next;
      act_n_q <= ~(~prog_mode & active_next);
    end
  end

  assign ir_pulse = ir_q;
  assign tx_act_n = act_n_q;
endmodule

// File: rtl/irsir_tx_shaper_checker.sv
module irsir_tx_shaper_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic prog_mode,
  input logic nrz_in,
  input logic ir_pulse,
  input logic tx_act_n
);
  // R1: reset drives both outputs inactive on the next clock
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ir_pulse && tx_act_n));

  // R2: a pulse can only begin after a low line sample
  p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_pulse) |-> !$past(nrz_in, SYNC_STAGES + 1));

  // R7: programming mode silences the infrared output
  p_prog_dark_r7: assert property (@(posedge clk) disable iff (rst)
    prog_mode |=> (!ir_pulse && tx_act_n));

  // R7: no pulse begins right after a programming-mode cycle
  p_prog_no_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_pulse) |-> !$past(prog_mode));

  // R8: the indicator is active whenever a pulse is out
  p_ind_covers_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ir_pulse |-> !tx_act_n);
endmodule

bind irsir_tx_shaper irsir_tx_shaper_checker #(.SYNC_STAGES(SYNC_STAGES)) u_checker (
  .clk(clk), .rst(rst), .prog_mode(prog_mode), .nrz_in(nrz_in),
  .ir_pulse(ir_pulse), .tx_act_n(tx_act_n)
);

// File: tb/irsir_tx_shaper_bench.sv
module irsir_tx_shaper_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_mode = 1'b0;
  logic nrz_in = 1'b1;
  logic sub_tick = 1'b0;
  logic fixed_width = 1'b1;
  logic ir_pulse, tx_act_n;

  always #10 clk = ~clk;

  irsir_tx_shaper u_irsir_tx_shaper (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .nrz_in(nrz_in),
    .sub_tick(sub_tick), .fixed_width(fixed_width),
    .ir_pulse(ir_pulse), .tx_act_n(tx_act_n)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int tdiv = 8, tcnt = 0;
  int rise_at[64];
  int wid[64];
  int npul = 0, run = 0, hi_cnt = 0, ind_low_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: sample outputs at the negedge, then drive the next inputs
  task automatic tick_cycle(input logic v);
    @(negedge clk);
    cyc++;
    if (ir_pulse === 1'b1) begin
      if (run == 0 && npul < 64) rise_at[npul] = cyc;
      run++;
      hi_cnt++;
    end else if (run > 0) begin
      if (npul < 64) wid[npul] = run;
      npul++;
      run = 0;
    end
    if (tx_act_n === 1'b0) ind_low_cnt++;
    nrz_in   = v;
    sub_tick = (tcnt == 0);
    tcnt     = (tcnt + 1) % tdiv;
  endtask

  task automatic clear_mon();
    npul = 0; run = 0; hi_cnt = 0; ind_low_cnt = 0;
  endtask

  task automatic send_bit(input logic v);
    repeat (16 * tdiv) tick_cycle(v);
  endtask

  task automatic t_reset();
    repeat (3) tick_cycle(1'b1);
    chk(ir_pulse === 1'b0, "R1", "ir_pulse in reset", ir_pulse, 0);
    chk(tx_act_n === 1'b1, "R1", "tx_act_n in reset", tx_act_n, 1);
    rst = 1'b0;
    tick_cycle(1'b1);
    chk(ir_pulse === 1'b0, "R1", "ir_pulse after reset", ir_pulse, 0);
    chk(tx_act_n === 1'b1, "R1", "tx_act_n after reset", tx_act_n, 1);
  endtask

  task automatic t_idle();
    tdiv = 4; tcnt = 0;
    clear_mon();
    repeat (300) tick_cycle(1'b1);
    chk(hi_cnt == 0, "R2", "pulse cycles on idle line", hi_cnt, 0);
  endtask

  // Sends start + 8 data bits (LSB first) + stop; checks every pulse
  task automatic run_frame(input logic [7:0] data, input int d,
                           input logic fx, input string tag);
    logic [9:0] bits;
    logic [9:0] ind;
    int c0, exp_n, idx, exp_r, exp_w;
    string rw;
    bits = {1'b1, data, 1'b0};
    tdiv = d; tcnt = 0; fixed_width = fx;
    send_bit(1'b1);
    clear_mon();
    c0 = cyc + 1;
    for (int p = 0; p < 10; p++) begin
      repeat (8 * d) tick_cycle(bits[p]);
      ind[p] = tx_act_n;
      repeat (8 * d) tick_cycle(bits[p]);
    end
    send_bit(1'b1);
    exp_n = 0;
    for (int p = 0; p < 10; p++) if (!bits[p]) exp_n++;
    chk(npul == exp_n, "R2", "pulse count", npul, exp_n);
    idx = 0;
    for (int p = 0; p < 10; p++) begin
      if (!bits[p] && idx < npul) begin
        logic edge_bit;
        edge_bit = (p == 0) ? 1'b1 : bits[p-1];
        exp_r = c0 + 16 * d * p + 3;
        chk(rise_at[idx] == exp_r, edge_bit ? "R6" : "R5", "rise cycle",
            rise_at[idx], exp_r);
        exp_w = fx ? 6 : 3 * d;
        rw = (tag.len() > 0) ? tag : (fx ? "R3" : "R4");
        chk(wid[idx] == exp_w, rw, "pulse width", wid[idx], exp_w);
        idx++;
      end
      chk(ind[p] == bits[p], "R8", "indicator mid-bit", ind[p], bits[p]);
    end
  endtask

  // Zero run starting off the tick grid: the edge restarts bit timing
  task automatic t_realign();
    int c0;
    tdiv = 8; tcnt = 0; fixed_width = 1'b1;
    send_bit(1'b1);
    tick_cycle(1'b1);
    tick_cycle(1'b1);
    clear_mon();
    c0 = cyc + 1;
    repeat (248) tick_cycle(1'b0);
    repeat (200) tick_cycle(1'b1);
    chk(npul == 2, "R6", "pulses in off-grid run", npul, 2);
    chk(rise_at[0] == c0 + 3, "R6", "edge pulse rise", rise_at[0], c0 + 3);
    chk(rise_at[1] == c0 + 129, "R6", "realigned boundary rise",
        rise_at[1], c0 + 129);
  endtask

  // Width select flipped right after the pulse has started
  task automatic t_latch(input logic fx_start, input int exp_w);
    tdiv = 8; tcnt = 0; fixed_width = fx_start;
    send_bit(1'b1);
    clear_mon();
    repeat (3) tick_cycle(1'b0);
    tick_cycle(1'b0);
    fixed_width = ~fx_start;
    repeat (16 * 8 - 4) tick_cycle(1'b0);
    send_bit(1'b1);
    chk(npul == 1, "R9", "pulse count", npul, 1);
    chk(wid[0] == exp_w, "R9", "width after select flip", wid[0], exp_w);
    fixed_width = 1'b1;
  endtask

  task automatic t_prog();
    tdiv = 4; tcnt = 0; fixed_width = 1'b1;
    send_bit(1'b1);
    prog_mode = 1'b1;
    tick_cycle(1'b1);
    clear_mon();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    chk(hi_cnt == 0, "R7", "pulse cycles in prog mode", hi_cnt, 0);
    chk(ind_low_cnt == 0, "R7", "indicator cycles in prog mode", ind_low_cnt, 0);
    repeat (10) tick_cycle(1'b0);
    prog_mode = 1'b0;
    clear_mon();
    repeat (100) tick_cycle(1'b0);
    chk(hi_cnt == 0, "R7", "pulse after leaving prog with line low", hi_cnt, 0);
    chk(ind_low_cnt == 0, "R7", "indicator after leaving prog", ind_low_cnt, 0);
    send_bit(1'b1);
    tcnt = 0;
    repeat (4) tick_cycle(1'b0);
    chk(ir_pulse === 1'b1, "R7", "pulse up before cut", ir_pulse, 1);
    prog_mode = 1'b1;
    tick_cycle(1'b0);
    chk(ir_pulse === 1'b0, "R7", "pulse cut by prog", ir_pulse, 0);
    chk(tx_act_n === 1'b1, "R7", "indicator off in prog", tx_act_n, 1);
    repeat (20) tick_cycle(1'b1);
    prog_mode = 1'b0;
    send_bit(1'b1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    run_frame(8'h06, 4, 1'b1, "");
    run_frame(8'h06, 8, 1'b0, "");
    run_frame(8'hFF, 4, 1'b1, "");
    run_frame(8'h00, 2, 1'b0, "R10");
    run_frame(8'h00, 2, 1'b1, "R10");
    t_realign();
    t_latch(1'b1, 6);
    t_latch(1'b0, 24);
    t_prog();
    finish_run();
  end
endmodule